// File: doc/BRIEF.md
# Panel Register Init Sequencer

This block brings a small display controller into a working state by writing a fixed list of register settings to it over a write-only SPI link. It starts on its own when reset is released, and it can be run again later with a one-cycle start pulse. Each setting is an address and a 16-bit value. The block sends each setting as two separate 24-bit transfers. The first transfer picks the register index and the second writes the value into that register. Each transfer has its own chip-select pulse and its own leading byte. Bit 1 of that leading byte tells the panel which of the two kinds of transfer it is.

The block drives a serial clock with mode-0 timing. The clock rate is a parameter-set fraction of the system clock. Between two transfers, chip select is held high for a minimum time that is also set by a parameter. The system flags a bad transfer through an external fault strobe. If the strobe is high at the end of a transfer, the run stops at once and an error flag is raised. When a run finishes cleanly, a one-cycle done pulse is given instead.

Top module: `panel_init_seq`

## Requirements
- R1: While rst_n is low, cs_n_o is 1, sclk_o is 0 and done_o and err_o are 0. After rst_n is released, a full run starts without any start pulse, with busy_o at 1.
- R2: Every transfer is exactly 24 serial bits, sent most significant bit first. cs_n_o is 0 for the whole transfer and returns to 1 at its end, so each transfer is a separate chip-select pulse.
- R3: Mode-0 timing applies. sclk_o rests at 0 whenever cs_n_o is 1. mosi_o changes only while sclk_o is 0 and is steady while sclk_o is 1. One sclk_o period is 2*CLK_DIV system clocks.
- R4: An index transfer is the byte 0x70 followed by 0x00 and then the 8-bit register address. A value transfer is the byte 0x72 followed by the 16-bit value, high byte first. The top six bits of the leading byte are 011100, bit 1 is 1 only for a value transfer, and bit 0 is 0.
- R5: For each entry, the index transfer is sent before the value transfer. The 24 entries are sent in this order, as address=value in hex: 01=6300, 02=0200, 03=6564, 04=04C7, 05=A884, 08=00CE, 0A=4008, 0B=D400, 0D=3229, 0E=1200, 0F=0000, 16=9F80, 17=3F02, 1E=005C, 30=0103, 31=0407, 32=0705, 33=0002, 34=0505, 35=0303, 36=0707, 37=0100, 3A=1F00, 3B=000F.
- R6: Between two transfers of the same run, cs_n_o stays 1 for at least 2*CLK_DIV*GAP_SCLK system clocks.
- R7: A clean run sends exactly 48 transfers. After the last one, done_o is 1 for exactly one cycle, and busy_o falls in that same cycle.
- R8: fault_i is sampled in the first cycle after cs_n_o returns to 1 at the end of a transfer. If it is 1 there, no further transfer is sent, cs_n_o stays 1, err_o rises, busy_o falls and done_o does not pulse.
- R9: err_o stays at 1 until the next accepted start pulse. That pulse clears err_o and runs the full table again from the first entry.
- R10: A start pulse that arrives while busy_o is 1 has no effect on the run. The run still sends the same 48 transfers in order and gives a single done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to run the table again |
| fault_i | input | 1 | External fault strobe, sampled at the end of each transfer |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the panel |
| cs_n_o | output | 1 | Active-low chip select, one pulse per transfer |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when a run finishes cleanly |
| err_o | output | 1 | Sticky flag: the last run was stopped by a fault |

## Verification
A wrong table index or a phase bit that does not toggle shows up at once on the wire. The very next transfer carries the wrong leading byte or the wrong payload, and the decoded frame miscompares within about one transfer time. A bit counter that is off shows up at that transfer's chip-select release as a frame that is not 24 bits long. A fault that is dropped, or a start that is taken while busy, shows up within one run as a wrong transfer count, a missing or doubled done pulse, or an err_o level that does not match.

// File: rtl/pinit_pkg.sv
package pinit_pkg;

  localparam int FRAME_W = 24;
  localparam int N_ENT   = 24;
  localparam logic [5:0] ID_BITS = 6'b011100;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_GAP
  } pinit_st_e;

  // leading byte: id pattern, register-select bit, write (0)
  function automatic logic [7:0] lead_byte(input logic is_value);
    return {ID_BITS, is_value, 1'b0};
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input logic is_value,
                                                     input logic [15:0] word);
    return {lead_byte(is_value), word};
  endfunction

endpackage

// File: rtl/pinit_rom.sv
module pinit_rom #(
  parameter int IW = 5
) (
  input  logic [IW-1:0] idx_i,
  output logic [7:0]    addr_o,
  output logic [15:0]   val_o
);

  always_comb begin
    case (idx_i)
      IW'(0):  {addr_o, val_o} = {8'h01, 16'h6300};
      IW'(1):  {addr_o, val_o} = {8'h02, 16'h0200};
      IW'(2):  {addr_o, val_o} = {8'h03, 16'h6564};
      IW'(3):  {addr_o, val_o} = {8'h04, 16'h04C7};
      IW'(4):  {addr_o, val_o} = {8'h05, 16'hA884};
      IW'(5):  {addr_o, val_o} = {8'h08, 16'h00CE};
      IW'(6):  {addr_o, val_o} = {8'h0A, 16'h4008};
      IW'(7):  {addr_o, val_o} = {8'h0B, 16'hD400};
      IW'(8):  {addr_o, val_o} = {8'h0D, 16'h3229};
      IW'(9):  {addr_o, val_o} = {8'h0E, 16'h1200};
      IW'(10): {addr_o, val_o} = {8'h0F, 16'h0000};
      IW'(11): {addr_o, val_o} = {8'h16, 16'h9F80};
      IW'(12): {addr_o, val_o} = {8'h17, 16'h3F02};
      IW'(13): {addr_o, val_o} = {8'h1E, 16'h005C};
      IW'(14): {addr_o, val_o} = {8'h30, 16'h0103};
      IW'(15): {addr_o, val_o} = {8'h31, 16'h0407};
      IW'(16): {addr_o, val_o} = {8'h32, 16'h0705};
      IW'(17): {addr_o, val_o} = {8'h33, 16'h0002};
      IW'(18): {addr_o, val_o} = {8'h34, 16'h0505};
      IW'(19): {addr_o, val_o} = {8'h35, 16'h0303};
      IW'(20): {addr_o, val_o} = {8'h36, 16'h0707};
      IW'(21): {addr_o, val_o} = {8'h37, 16'h0100};
      IW'(22): {addr_o, val_o} = {8'h3A, 16'h1F00};
      IW'(23): {addr_o, val_o} = {8'h3B, 16'h000F};
      default: {addr_o, val_o} = 24'h0;
    endcase
  end

endmodule

// File: rtl/pinit_shifter.sv
module pinit_shifter #(
  parameter int FW  = 24,
  parameter int DIV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [FW-1:0] frame_i,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          cs_n_o,
  output logic          end_o
);

  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW = $clog2(FW);

  logic [FW-1:0] sh_q;
  logic [DW-1:0] div_q;
  logic [BW-1:0] bit_q;
  logic          sclk_q, csn_q, end_q;

  wire half_tick = (div_q == DW'(DIV - 1));
  wire last_bit  = (bit_q == BW'(FW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      div_q  <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
      end_q  <= 1'b0;
    end else begin
      end_q <= 1'b0;
      if (load_i && csn_q) begin
        sh_q   <= frame_i;
        csn_q  <= 1'b0;
        div_q  <= '0;
        bit_q  <= '0;
        sclk_q <= 1'b0;
      end else if (!csn_q) begin
        if (half_tick) begin
          div_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
          end else begin
            sclk_q <= 1'b0;
            if (last_bit) begin
              csn_q <= 1'b1;
              end_q <= 1'b1;
            end else begin
              sh_q  <= {sh_q[FW-2:0], 1'b0};
              bit_q <= bit_q + 1'b1;
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = sh_q[FW-1];
  assign cs_n_o = csn_q;
  assign end_o  = end_q;

  // R3
  mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  // R2
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |-> (cs_n_o && $past(!cs_n_o)));

endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
  import pinit_pkg::*;
#(
  parameter int CLK_DIV  = 2,
  parameter int GAP_SCLK = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic fault_i,
  output logic sclk_o,
  output logic mosi_o,
  output logic cs_n_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);

  localparam int GAP_CYC = 2 * CLK_DIV * GAP_SCLK;
  localparam int GCW     = $clog2(GAP_CYC + 1) + 1;
  localparam int IW      = $clog2(N_ENT);

  pinit_st_e        st_q;
  logic [IW-1:0]    idx_q;
  logic             ph_q;
  logic [GCW-1:0]   gap_q;
  logic [GCW-1:0]   cs_hi_q;
  logic             busy_q, done_q, err_q;
  logic [7:0]       reg_a;
  logic [15:0]      reg_v;
  logic [FRAME_W-1:0] frame;
  logic             fr_end;

  // named internal events
  wire last_frame = ph_q && (idx_q == IW'(N_ENT - 1));
  wire fault_hit  = (st_q == ST_SHIFT) && fr_end && fault_i;
  wire seq_fin    = (st_q == ST_SHIFT) && fr_end && !fault_i && last_frame;
  wire step       = (st_q == ST_SHIFT) && fr_end && !fault_i && !last_frame;
  wire go         = (st_q == ST_IDLE) && start_i;
  wire gap_over   = (gap_q == GCW'(GAP_CYC - 1));
  wire load       = (st_q == ST_LOAD);
  wire run_first  = (idx_q == '0) && !ph_q;

  pinit_rom #(.IW(IW)) u_rom (
    .idx_i  (idx_q),
    .addr_o (reg_a),
    .val_o  (reg_v)
  );

  assign frame = build_frame(ph_q, ph_q ? reg_v : {8'h00, reg_a});

  pinit_shifter #(.FW(FRAME_W), .DIV(CLK_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .frame_i (frame),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .cs_n_o  (cs_n_o),
    .end_o   (fr_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_LOAD;
      idx_q  <= '0;
      ph_q   <= 1'b0;
      gap_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (go) begin
            st_q   <= ST_LOAD;
            idx_q  <= '0;
            ph_q   <= 1'b0;
            busy_q <= 1'b1;
            err_q  <= 1'b0;
          end
        end
        ST_LOAD: st_q <= ST_SHIFT;
        ST_SHIFT: begin
          if (fault_hit) begin
            err_q  <= 1'b1;
            busy_q <= 1'b0;
            st_q   <= ST_IDLE;
          end else if (seq_fin) begin
            done_q <= 1'b1;
            busy_q <= 1'b0;
            st_q   <= ST_IDLE;
          end else if (step) begin
            gap_q <= '0;
            st_q  <= ST_GAP;
            if (ph_q) begin
              ph_q  <= 1'b0;
              idx_q <= idx_q + 1'b1;
            end else begin
              ph_q <= 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (gap_over) st_q <= ST_LOAD;
          else          gap_q <= gap_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // chip-select high time, kept for the gap check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cs_hi_q <= '0;
    else if (!cs_n_o)              cs_hi_q <= '0;
    else if (cs_hi_q != '1)        cs_hi_q <= cs_hi_q + 1'b1;
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  // R6
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n_o) && !run_first) |-> (cs_hi_q >= GCW'(GAP_CYC)));

  // R7
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !err_o && $past(busy_o)));

  // R8
  err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (cs_n_o && !busy_o && !done_o));

  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> cs_n_o);

endmodule

// File: tb/sim_panel_init_seq.sv
module sim_panel_init_seq;

  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 2;
  localparam int GAPS = 2;
  localparam int GAP_CYC = 2 * DIV * GAPS;

  logic clk = 1'b0;
  logic rst_n, start_i, fault_i;
  logic sclk_o, mosi_o, cs_n_o, busy_o, done_o, err_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  panel_init_seq #(.CLK_DIV(DIV), .GAP_SCLK(GAPS)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fault_i(fault_i),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  int vec = 0, mis = 0;
  int tclk = 0;
  int nfr, nfalls, bitcnt, len_viol, gap_viol, m0_viol, done_cnt, hi_cnt;
  int last_rise;
  bit rise_seen;
  logic [23:0] shin;
  logic [23:0] got [0:63];
  logic sclk_prev = 1'b0, mosi_prev = 1'b0, cs_prev = 1'b1;

  // panel settings, entry order (R5)
  function automatic logic [23:0] entry(input int e);
    logic [23:0] t [0:23];
    t = '{24'h016300, 24'h020200, 24'h036564, 24'h0404C7, 24'h05A884, 24'h0800CE,
          24'h0A4008, 24'h0BD400, 24'h0D3229, 24'h0E1200, 24'h0F0000, 24'h169F80,
          24'h173F02, 24'h1E005C, 24'h300103, 24'h310407, 24'h320705, 24'h330002,
          24'h340505, 24'h350303, 24'h360707, 24'h370100, 24'h3A1F00, 24'h3B000F};
    return t[e];
  endfunction

  // expected transfer n of a run (R4, R5)
  function automatic logic [23:0] want_frame(input int n);
    logic [23:0] p;
    p = entry(n / 2);
    if ((n % 2) == 0) return {8'b0111_0000, 8'h00, p[23:16]};
    return {8'b0111_0010, p[15:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      mis++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // wire monitor, sampled away from the active edge
  always @(negedge clk) begin
    tclk++;
    if (rst_n) begin
      if (sclk_o && sclk_prev && (mosi_o !== mosi_prev)) m0_viol++;
      if (cs_n_o && sclk_o) m0_viol++;
      if (sclk_o && !sclk_prev) begin
        if (rise_seen && (tclk - last_rise != 2 * DIV)) m0_viol++;
        last_rise = tclk;
        rise_seen = 1'b1;
        shin = {shin[22:0], mosi_o};
        bitcnt++;
      end
      if (!cs_n_o && cs_prev) begin
        if (nfr > 0 && hi_cnt < GAP_CYC) gap_viol++;
        nfalls++;
        bitcnt = 0;
      end
      if (cs_n_o && !cs_prev) begin
        if (bitcnt != 24) len_viol++;
        if (nfr < 64) got[nfr] = shin;
        nfr++;
      end
      if (cs_n_o) begin
        hi_cnt++;
        rise_seen = 1'b0;
      end else begin
        hi_cnt = 0;
      end
      if (done_o) done_cnt++;
    end
    sclk_prev = sclk_o;
    mosi_prev = mosi_o;
    cs_prev   = cs_n_o;
  end

  task automatic clr();
    nfr = 0; nfalls = 0; bitcnt = 0; len_viol = 0; gap_viol = 0;
    m0_viol = 0; done_cnt = 0; hi_cnt = 0; rise_seen = 1'b0; shin = '0;
  endtask

  task automatic pulse_start();
    clr();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R9 busy after start", {31'b0, busy_o}, 32'd1);
    chk("R9 err cleared by start", {31'b0, err_o}, 32'd0);
  endtask

  task automatic wait_run(input int fault_at, input bit poke);
    int cyc = 0;
    while (busy_o && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      start_i = poke && (cyc == 700 || cyc == 3100);
      if (fault_at >= 0 && nfalls == fault_at + 1 && !cs_n_o) fault_i = 1'b1;
    end
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    fault_i = 1'b0;
  endtask

  task automatic chk_run(input int n_exp, input bit bad);
    chk(bad ? "R8 transfer count" : "R7 transfer count", nfr, n_exp);
    for (int i = 0; i < n_exp && i < 64; i++)
      chk("R5 R4 transfer content", got[i], want_frame(i));
    chk("R2 frame length", len_viol, 0);
    chk("R3 mode-0 timing", m0_viol, 0);
    chk("R6 chip-select gap", gap_viol, 0);
    chk(bad ? "R8 no done" : "R7 done pulse", done_cnt, bad ? 0 : 1);
    chk(bad ? "R8 err raised" : "R7 err low", {31'b0, err_o}, {31'b0, bad});
    chk("R7 R8 busy low", {31'b0, busy_o}, 32'd0);
    chk("R8 bus released", {31'b0, cs_n_o}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mis++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end

  initial begin
    void'($urandom(32'd1729));
    rst_n = 1'b0; start_i = 1'b0; fault_i = 1'b0;
    clr();
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n in reset", {31'b0, cs_n_o}, 32'd1);
    chk("R1 sclk in reset", {31'b0, sclk_o}, 32'd0);
    chk("R1 done in reset", {31'b0, done_o}, 32'd0);
    chk("R1 err in reset", {31'b0, err_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 auto run busy", {31'b0, busy_o}, 32'd1);
    // boot run with start pokes while busy (R10)
    wait_run(-1, 1'b1);
    chk_run(48, 1'b0);

    // idle: err stays low, no transfers
    repeat (20) @(negedge clk);
    chk("R10 idle no extra transfers", nfr, 48);

    // directed faults on first and last transfer
    pulse_start(); wait_run(0, 1'b0);  chk_run(1, 1'b1);
    repeat (30) @(negedge clk);
    chk("R9 err sticky", {31'b0, err_o}, 32'd1);
    chk("R8 nothing sent after fault", nfr, 1);
    pulse_start(); wait_run(47, 1'b0); chk_run(48, 1'b1);

    // random fault positions, random idle gaps
    for (int k = 0; k < 6; k++) begin
      int fa;
      fa = 1 + int'($urandom_range(45, 0));
      repeat (1 + $urandom_range(20, 0)) @(negedge clk);
      pulse_start(); wait_run(fa, $urandom_range(1, 0) == 1);
      chk_run(fa + 1, 1'b1);
    end

    // clean rerun after error (R9), with pokes (R10)
    pulse_start(); wait_run(-1, 1'b1); chk_run(48, 1'b0);
    pulse_start(); wait_run(-1, 1'b0); chk_run(48, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end

endmodule